// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Register

This block is the arithmetic and logic stage of a small 8-bit processor core. Every cycle it takes an operation code and two byte operands. It returns the byte result at once, with no clock delay, together with a write-enable for the destination register. It also holds the machine status flags in its own register: carry, zero, negative, overflow, sign, half-carry and the bit-store flag.

When `exec_i` is high, the flags computed for the current operation are loaded on the next rising clock edge. When it is low, they hold.

Carry-in for add-with-carry and borrow-in for subtract-with-carry and rotate come from the stored carry flag. Flag logic is built from per-bit carry and borrow vectors.

The chained subtract and compare operations can only clear zero, never set it. This lets a multi-byte compare leave zero set only when every byte matched.

Top module: `alu8_status`

## Requirements
- R1: ADD (op 0) returns a+b and ADC (op 1) returns a+b+C, mod 256. C is bit 7 of carry vector (a&b)|(b&~res)|(~res&a) and H is its bit 3. V is bit 7 of (a&b&~res)|(~a&~b&res). Z means the result is zero and N is result bit 7.
- R2: SUB (op 2) returns a-b and SBC (op 3) returns a-b-C, mod 256. C is bit 7 of borrow vector (~a&b)|(b&res)|(res&~a) and H is its bit 3. V is bit 7 of (a&~b&~res)|(~a&b&res). N is result bit 7. For SUB, Z means the result is zero.
- R3: SBC (op 3) and CPC (op 5) clear Z when the result is nonzero and leave Z unchanged when it is zero.
- R4: CMP (op 4, a-b) and CPC (op 5, a-b-C) update flags exactly as SUB and SBC do, but hold wr_en_o low.
- R5: AND (op 6), OR (op 7) and XOR (op 8) return the bitwise result. They clear V, set N and Z from the result, and leave C and H unchanged.
- R6: COM (op 9) returns ~a, sets C, clears V, sets N and Z from the result, and leaves H unchanged.
- R7: NEG (op 10) returns 0-a. C is set when the result is nonzero, V when the result is 0x80, and H from bit 3 of (a|res). N and Z come from the result.
- R8: INC (op 11) and DEC (op 12) return a+1 and a-1. V is set exactly when the result is 0x80 (INC) or 0x7F (DEC). N and Z come from the result, and C and H are unchanged.
- R9: LSR (op 13), ASR (op 14) and ROR (op 15) shift a right by one. LSR fills bit 7 with 0, ASR keeps bit 7, and ROR inserts the old C. C takes a bit 0, N is result bit 7 (0 for LSR), V = N^C, Z comes from the result, and H is unchanged.
- R10: SWAP (op 16) exchanges the nibbles of a and leaves every flag unchanged.
- R11: flags_o bits are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, and all are zero after reset. After every operation S = N^V, and T never changes.
- R12: With exec_i low, wr_en_o is low and the flags hold. Codes 17 to 31 deassert wr_en_o and leave the flags unchanged. Flags change one clock edge after an executed operation, while res_o follows the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | 8 | Destination operand / single operand |
| b_i | input | 8 | Source operand |
| res_o | output | 8 | Combinational result |
| wr_en_o | output | 1 | Write result back to the destination |
| flags_o | output | 7 | Registered status flags {T,H,S,V,N,Z,C} |

## Verification
The hardest state to reach is a chained compare that starts with Z set and then passes through both a zero and a nonzero partial result. Z must then stay clear even after a later byte matches.

Random stimulus seldom lines this up, so directed sequences run CMP on equal bytes, then CPC on equal bytes, then CPC on unequal bytes, then CPC on equal bytes again. The random part draws about half its operands from the edge values 0x00, 0x01, 0x7F, 0x80 and 0xFF, so that the INC, DEC and NEG overflow points and the carry and borrow corners recur.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  parameter int ALU_W = 8;
  localparam int MSB    = ALU_W - 1;
  localparam int HALF_B = ALU_W / 2 - 1;

  typedef logic [ALU_W-1:0] word_t;

  localparam word_t SIGN_ONLY = {1'b1, {(ALU_W-1){1'b0}}};
  localparam word_t MAX_POS   = {1'b0, {(ALU_W-1){1'b1}}};

  typedef struct packed {
    logic t;
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP  = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_LSR = 5'd13, OP_ASR = 5'd14, OP_ROR = 5'd15,
    OP_SWAP = 5'd16
  } op_e;

  function automatic word_t carry_vec(word_t d, word_t r, word_t res);
    return (d & r) | (r & ~res) | (~res & d);
  endfunction

  function automatic word_t borrow_vec(word_t d, word_t r, word_t res);
    return (~d & r) | (r & res) | (res & ~d);
  endfunction

  function automatic logic add_ovf(word_t d, word_t r, word_t res);
    word_t t;
    t = (d & r & ~res) | (~d & ~r & res);
    return t[MSB];
  endfunction

  function automatic logic sub_ovf(word_t d, word_t r, word_t res);
    word_t t;
    t = (d & ~r & ~res) | (~d & r & res);
    return t[MSB];
  endfunction

  function automatic logic is_arith(op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC,
                      OP_NEG, OP_INC, OP_DEC};
  endfunction

  function automatic logic is_logic(op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR, OP_COM, OP_SWAP};
  endfunction

  function automatic logic is_shift(op_e op);
    return op inside {OP_LSR, OP_ASR, OP_ROR};
  endfunction

  function automatic logic is_compare(op_e op);
    return op inside {OP_CMP, OP_CPC};
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  op_e    op,
  input  word_t  a,
  input  word_t  b,
  input  flags_t f_in,
  output word_t  res,
  output flags_t f_out
);
  word_t cvec;
  logic  cy_in;
  logic  chained;

  assign chained = (op == OP_SBC) || (op == OP_CPC);

  always_comb begin
    f_out = f_in;
    res   = a;
    cvec  = '0;
    cy_in = 1'b0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        cy_in   = (op == OP_ADC) ? f_in.c : 1'b0;
        res     = a + b + word_t'(cy_in);
        cvec    = carry_vec(a, b, res);
        f_out.h = cvec[HALF_B];
        f_out.c = cvec[MSB];
        f_out.v = add_ovf(a, b, res);
        f_out.z = (res == '0);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CPC: begin
        cy_in   = chained ? f_in.c : 1'b0;
        res     = a - b - word_t'(cy_in);
        cvec    = borrow_vec(a, b, res);
        f_out.h = cvec[HALF_B];
        f_out.c = cvec[MSB];
        f_out.v = sub_ovf(a, b, res);
        f_out.z = chained ? (f_in.z & (res == '0)) : (res == '0);
      end
      OP_NEG: begin
        res     = '0 - a;
        cvec    = a | res;
        f_out.h = cvec[HALF_B];
        f_out.c = (res != '0);
        f_out.v = (res == SIGN_ONLY);
        f_out.z = (res == '0);
      end
      OP_INC: begin
        res     = a + word_t'(1);
        f_out.v = (res == SIGN_ONLY);
        f_out.z = (res == '0);
      end
      OP_DEC: begin
        res     = a - word_t'(1);
        f_out.v = (res == MAX_POS);
        f_out.z = (res == '0);
      end
      default: ;
    endcase
    if (is_arith(op)) begin
      f_out.n = res[MSB];
      f_out.s = f_out.n ^ f_out.v;
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  op_e    op,
  input  word_t  a,
  input  word_t  b,
  input  flags_t f_in,
  output word_t  res,
  output flags_t f_out
);
  localparam int NIB = ALU_W / 2;

  always_comb begin
    f_out = f_in;
    res   = a;
    unique case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_COM: res = ~a;
      OP_SWAP: res = {a[NIB-1:0], a[ALU_W-1:NIB]};
      default: ;
    endcase
    if (op inside {OP_AND, OP_OR, OP_XOR, OP_COM}) begin
      f_out.v = 1'b0;
      f_out.n = res[MSB];
      f_out.z = (res == '0);
      f_out.s = res[MSB];
      if (op == OP_COM) f_out.c = 1'b1;
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  op_e    op,
  input  word_t  a,
  input  flags_t f_in,
  output word_t  res,
  output flags_t f_out
);
  logic fill;

  always_comb begin
    unique case (op)
      OP_ASR:  fill = a[MSB];
      OP_ROR:  fill = f_in.c;
      default: fill = 1'b0;
    endcase
    res   = {fill, a[MSB:1]};
    f_out = f_in;
    if (is_shift(op)) begin
      f_out.c = a[0];
      f_out.n = res[MSB];
      f_out.v = res[MSB] ^ a[0];
      f_out.s = a[0];
      f_out.z = (res == '0);
    end
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q == $past(q));

  // R11
  t_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q.t == $past(q.t));

  // R11
  sign_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q.s == (q.n ^ q.v));
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec_i,
  input  logic [4:0]           op_i,
  input  logic [ALU_W-1:0]     a_i,
  input  logic [ALU_W-1:0]     b_i,
  output logic [ALU_W-1:0]     res_o,
  output logic                 wr_en_o,
  output logic [6:0]           flags_o
);
  op_e    op;
  flags_t flags_q;
  flags_t f_ar, f_lg, f_sh, f_nxt;
  word_t  r_ar, r_lg, r_sh;
  logic   op_known;
  logic   cmp_event;

  assign op        = op_e'(op_i);
  assign op_known  = is_arith(op) || is_logic(op) || is_shift(op);
  assign cmp_event = exec_i && is_compare(op);

  alu8_arith u_arith (.op(op), .a(a_i), .b(b_i), .f_in(flags_q),
                      .res(r_ar), .f_out(f_ar));
  alu8_logic u_logic (.op(op), .a(a_i), .b(b_i), .f_in(flags_q),
                      .res(r_lg), .f_out(f_lg));
  alu8_shift u_shift (.op(op), .a(a_i), .f_in(flags_q),
                      .res(r_sh), .f_out(f_sh));

  always_comb begin
    if (is_arith(op)) begin
      res_o = r_ar;  f_nxt = f_ar;
    end else if (is_logic(op)) begin
      res_o = r_lg;  f_nxt = f_lg;
    end else if (is_shift(op)) begin
      res_o = r_sh;  f_nxt = f_sh;
    end else begin
      res_o = a_i;   f_nxt = flags_q;
    end
  end

  assign wr_en_o = exec_i && op_known && !is_compare(op);

  alu8_flagreg u_flags (.clk(clk), .rst_n(rst_n), .load(exec_i),
                        .d(f_nxt), .q(flags_q));

  assign flags_o = flags_q;

  // R4
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |-> !wr_en_o);

  // R3
  chain_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && (op == OP_SBC || op == OP_CPC) && !flags_q.z |=> !flags_q.z);

  // R10
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op == OP_SWAP |=> flags_q == $past(flags_q));

  // R6
  com_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && op == OP_COM |=> flags_q.c && !flags_q.v);

  // R12
  unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i && !op_known |=> flags_q == $past(flags_q));
endmodule

// File: tb/alu8_status_test.sv
`timescale 1ns/1ps
module alu8_status_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0;
  logic [7:0] res_o;
  logic       wr_en_o;
  logic [6:0] flags_o;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_flags = '0;
  string prev_tag = "R11";
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8_status uut (.clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
                   .a_i(a_i), .b_i(b_i), .res_o(res_o), .wr_en_o(wr_en_o),
                   .flags_o(flags_o));

  function automatic string tag_of(logic [4:0] op);
    if (op <= 1) return "R1";
    if (op == 2) return "R2";
    if (op == 3 || op == 5) return "R3";
    if (op == 4) return "R4";
    if (op <= 8) return "R5";
    if (op == 9) return "R6";
    if (op == 10) return "R7";
    if (op <= 12) return "R8";
    if (op <= 15) return "R9";
    if (op == 16) return "R10";
    return "R12";
  endfunction

  // returns {we, res[7:0], flags[6:0]}; flags {t,h,s,v,n,z,c}
  function automatic logic [15:0] model(logic [4:0] op, logic [7:0] a,
                                        logic [7:0] b, logic [6:0] f, logic ex);
    int ai, bi, ci, k, s;
    logic [7:0] r;
    logic c, z, n, v, h, we;
    ai = a; bi = b; ci = f[0];
    c = f[0]; z = f[1]; n = f[2]; v = f[3]; h = f[5];
    r = a; we = ex;
    case (op)
      0, 1: begin
        k = (op == 1) ? ci : 0;
        s = ai + bi + k; r = s[7:0];
        c = s > 255; h = ((ai % 16) + (bi % 16) + k) > 15;
        v = (a[7] == b[7]) && (r[7] != a[7]); z = (r == 0); n = r[7];
      end
      2, 3, 4, 5: begin
        k = (op == 3 || op == 5) ? ci : 0;
        s = ai - bi - k; r = s[7:0];
        c = ai < bi + k; h = (ai % 16) < (bi % 16) + k;
        v = (a[7] != b[7]) && (r[7] != a[7]); n = r[7];
        z = (op == 3 || op == 5) ? (f[1] && r == 0) : (r == 0);
        if (op == 4 || op == 5) we = 0;
      end
      6, 7, 8, 9: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (op == 8) ? (a ^ b) : 8'(255 - ai);
        v = 0; n = r[7]; z = (r == 0);
        if (op == 9) c = 1;
      end
      10: begin
        r = 8'(256 - ai); c = (r != 0); v = (r == 8'h80);
        h = ((ai | int'(r)) >> 3) & 1; n = r[7]; z = (r == 0);
      end
      11: begin r = 8'(ai + 1); v = (r == 8'h80); n = r[7]; z = (r == 0); end
      12: begin r = 8'(ai - 1); v = (r == 8'h7F); n = r[7]; z = (r == 0); end
      13, 14, 15: begin
        k = (op == 14) ? (ai & 128) : (op == 15) ? ci * 128 : 0;
        r = 8'((ai / 2) + k); c = a[0]; n = r[7]; v = n ^ c; z = (r == 0);
      end
      16: r = {a[3:0], a[7:4]};
      default: we = 0;
    endcase
    if (op <= 15) s = 1; else s = 0;
    if (!ex || op > 16) return {we & ex, r, f};
    if (op == 16) return {we, r, f};
    return {we, r, f[6], h, n ^ v, v, n, z, c};
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run(logic [4:0] op, logic [7:0] a, logic [7:0] b, logic ex);
    logic [15:0] m;
    @(negedge clk);
    check(prev_tag, "flags", {9'd0, flags_o}, {9'd0, exp_flags});
    op_i = op; a_i = a; b_i = b; exec_i = ex;
    #1;
    m = model(op, a, b, exp_flags, ex);
    prev_tag = ex ? tag_of(op) : "R12";
    if (op <= 16) check(prev_tag, "result", {7'd0, res_o}, {7'd0, m[14:7]});
    check(prev_tag, "write enable", {15'd0, wr_en_o}, {15'd0, m[15]});
    exp_flags = m[6:0];
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] edges [5];
    edges[0] = 8'h00; edges[1] = 8'h01; edges[2] = 8'h7F;
    edges[3] = 8'h80; edges[4] = 8'hFF;
    if ($urandom_range(0, 1) == 0) return edges[$urandom_range(0, 4)];
    return 8'($urandom_range(0, 255));
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset flags", {9'd0, flags_o}, 16'd0);
    rst_n = 1'b1;
    // R1 carries and overflow
    run(0, 8'h7F, 8'h01, 1);
    run(0, 8'hFF, 8'h01, 1);
    run(1, 8'h10, 8'h20, 1);
    // R2 borrow
    run(2, 8'h00, 8'h01, 1);
    run(3, 8'h05, 8'h05, 1);
    // R3 / R4 chained compare
    run(4, 8'h12, 8'h12, 1);
    run(5, 8'h34, 8'h34, 1);
    run(5, 8'h35, 8'h34, 1);
    run(5, 8'h34, 8'h34, 1);
    // R6, R7, R8
    run(9, 8'h5A, 8'h00, 1);
    run(10, 8'h80, 8'h00, 1);
    run(10, 8'h00, 8'h00, 1);
    run(10, 8'h01, 8'h00, 1);
    run(11, 8'h7F, 8'h00, 1);
    run(12, 8'h80, 8'h00, 1);
    // R9 shifts, ROR with C set
    run(9, 8'h00, 8'h00, 1);
    run(15, 8'h02, 8'h00, 1);
    run(13, 8'h01, 8'h00, 1);
    run(14, 8'h81, 8'h00, 1);
    // R5, R10
    run(6, 8'hF0, 8'h0F, 1);
    run(16, 8'hA5, 8'h00, 1);
    // R12 idle and undefined codes
    run(0, 8'hFF, 8'hFF, 0);
    run(20, 8'h33, 8'h44, 1);
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 40) == 0) ? 5'(17 + $urandom_range(0, 14))
                                         : 5'($urandom_range(0, 16));
      run(op, pick(), pick(), $urandom_range(0, 7) != 0);
    end
    @(negedge clk);
    check(prev_tag, "flags", {9'd0, flags_o}, {9'd0, exp_flags});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule